// File: doc/BRIEF.md
# Gated Reloading Counter/Timer

This block is a 16-bit counter built from two byte registers. It has two reload registers whose contents are copied back into the count each time the count wraps past all-ones. It counts one of two things, picked by a source bit: internal machine-cycle ticks, which are the clock divided by 12, or falling edges seen on an external event pin. A run bit enables counting. When the gate bit is set, counting also requires an external gate pin to be high.

A single control byte holds the gate, source, overflow-flag and run bits. Its lowest nibble holds the external-interrupt mode and pending bits. The timer stores these four bits and reads them back, but does not act on them. Every wrap sets the overflow flag, which goes to the interrupt logic. The flag is cleared by an acknowledge strobe from the vectoring logic, by a software write of zero to it, or by reset. The count bytes, the reload bytes and the control byte are all readable and writable through a simple byte-wide register port.

Top module: `gated_reload_timer`

## Requirements
- R1: While the active-low reset is low, the count bytes, the reload bytes, every control bit and the overflow output are zero.
- R2: The register port maps address 0 to the control byte, 1 to the count low byte, 2 to the count high byte, 3 to the reload low byte and 4 to the reload high byte. Addresses 5 to 7 read as zero. A write takes effect at the next clock edge, and the read data is a combinational view of the addressed register.
- R3: In the control byte, bit 7 is gate, bit 6 is source, bit 5 is the overflow flag and bit 4 is run. With source 0 and counting enabled, the count rises by exactly one every 12th clock, paced by a free-running divide-by-12 that starts at reset.
- R4: With source 1, the event pin passes through two synchronizing flops and is sampled once per machine cycle. A sample of 1 followed by a sample of 0 adds exactly one to the count.
- R5: With run 0 the count holds its value. With gate 1 and the gate pin low, the count also holds. With gate 0, the run bit alone enables counting.
- R6: When an increment finds the count at 0xFFFF, the next count is the 16-bit value held in the reload registers.
- R7: Every such wrap sets the overflow flag, which appears both on the ovfFlag output and in bit 5 of the control byte.
- R8: The acknowledge input clears the flag at the next edge. A wrap in the same cycle wins over both the acknowledge and a software write of bit 5.
- R9: A software write to a count byte in the same cycle as a reload or an increment wins for that byte. The other byte still takes its reloaded or incremented value.
- R10: Control bits 3 to 0 are stored and read back unchanged, and they have no effect on counting or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator) |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the addressed register |
| extEventPin | input | 1 | External event input, counted on falling edges |
| gatePin | input | 1 | External gate input, used when gate is set |
| vecAck | input | 1 | Vectoring acknowledge, clears the overflow flag |
| ovfFlag | output | 1 | Overflow flag toward the interrupt logic |

## Verification
Two kinds of same-cycle collision are exercised. In the first, a wrap lands in the same cycle as the acknowledge. In the second, a wrap lands in the same cycle as a software write to a count byte. To provoke each one, the bench parks the count at 0xFFFF and holds the acknowledge, or the byte write, high across a whole machine-cycle window, so the colliding edge cannot be missed. A behavioural reference model then judges every cycle. It applies the stated priorities: a wrap sets the flag over a clear, and a byte write wins over the reload for that byte only.

// File: rtl/gr_timer_pkg.sv
package gr_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CHI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RLO  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RHI  = 3'd4;

  localparam int BIT_GATE = 7;
  localparam int BIT_SRC  = 6;
  localparam int BIT_FLAG = 5;
  localparam int BIT_RUN  = 4;

  typedef struct packed {
    logic incEn;
    logic wrCtrl;
    logic wrLo;
    logic wrHi;
    logic wrRlLo;
    logic wrRlHi;
    logic vecAck;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import gr_timer_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              extEventPin,
  input  logic              gatePin,
  input  logic              vecAck,
  input  logic              gateBit,
  input  logic              srcBit,
  input  logic              runBit,
  output tmrStrobe_t        stb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]       prescCnt;
  logic                   machTick;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   sampQ;
  logic                   pinEvent;
  logic                   countEn;

  assign machTick = (prescCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescCnt <= '0;
    else if (machTick) prescCnt <= '0;
    else prescCnt <= prescCnt + 1'b1;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_multiSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], extEventPin};
      end
    end else begin : g_singleSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else syncQ <= extEventPin;
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampQ <= 1'b0;
    else if (machTick) sampQ <= syncOut;
  end

  assign pinEvent = machTick & sampQ & ~syncOut;
  assign countEn  = runBit & (~gateBit | gatePin);

  always_comb begin
    stb        = '0;
    stb.incEn  = countEn & (srcBit ? pinEvent : machTick);
    stb.wrCtrl = regWrEn & (regAddr == ADDR_CTRL);
    stb.wrLo   = regWrEn & (regAddr == ADDR_CLO);
    stb.wrHi   = regWrEn & (regAddr == ADDR_CHI);
    stb.wrRlLo = regWrEn & (regAddr == ADDR_RLO);
    stb.wrRlHi = regWrEn & (regAddr == ADDR_RHI);
    stb.vecAck = vecAck;
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import gr_timer_pkg::*;
#(
  parameter int COUNT_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         stb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BYTE_W-1:0]  regWrData,
  output logic [BYTE_W-1:0]  regRdData,
  output logic               gateBit,
  output logic               srcBit,
  output logic               runBit,
  output logic               flagBit,
  output logic [COUNT_W-1:0] countWord,
  output logic [COUNT_W-1:0] reloadWord
);
  logic [BYTE_W-1:0]  cntLo, cntHi, rlLo, rlHi;
  logic [3:0]         lowNib;
  logic               wrapNow;
  logic [COUNT_W-1:0] nextCount;
  logic [BYTE_W-1:0]  ctrlByte;

  assign countWord  = {cntHi, cntLo};
  assign reloadWord = {rlHi, rlLo};
  assign wrapNow    = stb.incEn & (&countWord);

  always_comb begin
    if (wrapNow) nextCount = reloadWord;
    else if (stb.incEn) nextCount = countWord + 1'b1;
    else nextCount = countWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else begin
      cntLo <= stb.wrLo ? regWrData : nextCount[BYTE_W-1:0];
      cntHi <= stb.wrHi ? regWrData : nextCount[COUNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rlLo <= '0;
      rlHi <= '0;
    end else begin
      if (stb.wrRlLo) rlLo <= regWrData;
      if (stb.wrRlHi) rlHi <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateBit <= 1'b0;
      srcBit  <= 1'b0;
      runBit  <= 1'b0;
      lowNib  <= '0;
    end else if (stb.wrCtrl) begin
      gateBit <= regWrData[BIT_GATE];
      srcBit  <= regWrData[BIT_SRC];
      runBit  <= regWrData[BIT_RUN];
      lowNib  <= regWrData[3:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagBit <= 1'b0;
    else if (wrapNow) flagBit <= 1'b1;
    else if (stb.vecAck) flagBit <= 1'b0;
    else if (stb.wrCtrl) flagBit <= regWrData[BIT_FLAG];
  end

  assign ctrlByte = {gateBit, srcBit, flagBit, runBit, lowNib};

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlByte;
      ADDR_CLO:  regRdData = cntLo;
      ADDR_CHI:  regRdData = cntHi;
      ADDR_RLO:  regRdData = rlLo;
      ADDR_RHI:  regRdData = rlHi;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer
  import gr_timer_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              extEventPin,
  input  logic              gatePin,
  input  logic              vecAck,
  output logic              ovfFlag
);
  localparam int COUNT_W = 2 * BYTE_W;

  tmrStrobe_t         stb;
  logic               gateBit, srcBit, runBit, flagBit;
  logic [COUNT_W-1:0] countWord, reloadWord;

  timer_ctrl #(.PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .extEventPin(extEventPin), .gatePin(gatePin), .vecAck(vecAck),
    .gateBit(gateBit), .srcBit(srcBit), .runBit(runBit), .stb(stb)
  );

  timer_datapath #(.COUNT_W(COUNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .gateBit(gateBit), .srcBit(srcBit), .runBit(runBit), .flagBit(flagBit),
    .countWord(countWord), .reloadWord(reloadWord)
  );

  assign ovfFlag = flagBit;
endmodule

// File: rtl/timer_chk.sv
module timer_chk
  import gr_timer_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input tmrStrobe_t  stb,
  input logic        gatePin,
  input logic        gateBit,
  input logic        ovfFlag,
  input logic [15:0] countWord,
  input logic [15:0] reloadWord
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (countWord == 16'h0 && reloadWord == 16'h0 && !ovfFlag));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incEn && countWord == 16'hFFFF) |=> ovfFlag);

  // R6
  reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incEn && countWord == 16'hFFFF && !stb.wrLo && !stb.wrHi)
    |=> countWord == $past(reloadWord));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.incEn && !stb.wrLo && !stb.wrHi) |=> $stable(countWord));

  // R5
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateBit && !gatePin) |-> !stb.incEn);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecAck && !(stb.incEn && countWord == 16'hFFFF)) |=> !ovfFlag);
endmodule

bind gated_reload_timer timer_chk chk_i (
  .clk(clk), .rstN(rstN), .stb(stb), .gatePin(gatePin), .gateBit(gateBit),
  .ovfFlag(ovfFlag), .countWord(countWord), .reloadWord(reloadWord)
);

// File: tb/gated_reload_timer_tb.sv
module gated_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       extEventPin = 1'b1;
  logic       gatePin = 1'b0;
  logic       vecAck = 1'b0;
  logic       ovfFlag;

  int testsRun = 0;
  int testsFailed = 0;
  string phaseTag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  gated_reload_timer dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .extEventPin(extEventPin),
    .gatePin(gatePin), .vecAck(vecAck), .ovfFlag(ovfFlag)
  );

  // behavioural reference
  int mCount, mReload, mPresc;
  int mLow, mFlag, mGate, mSrc, mRun;
  int pinHist[$];
  int mSamp;

  function automatic int modelReg(input int a);
    case (a)
      0: return (mGate << 7) | (mSrc << 6) | (mFlag << 5) | (mRun << 4) | mLow;
      1: return mCount & 255;
      2: return (mCount >> 8) & 255;
      3: return mReload & 255;
      4: return (mReload >> 8) & 255;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mReload = 0; mPresc = 0; mLow = 0; mFlag = 0;
      mGate = 0; mSrc = 0; mRun = 0; mSamp = 0;
      pinHist = '{0, 0};
    end else begin
      int tick, evt, en, inc, wrap, nxt, synced, d, a;
      tick = (mPresc == 11);
      mPresc = tick ? 0 : mPresc + 1;
      synced = pinHist[0];
      evt = tick && mSamp == 1 && synced == 0;
      if (tick) mSamp = synced;
      void'(pinHist.pop_front());
      pinHist.push_back(int'(extEventPin));
      en = mRun && (!mGate || gatePin);
      inc = en && (mSrc ? evt : tick);
      wrap = inc && mCount == 65535;
      nxt = wrap ? mReload : (inc ? (mCount + 1) & 65535 : mCount);
      d = int'(regWrData);
      a = int'(regAddr);
      if (regWrEn && a == 1) nxt = (nxt & 16'hFF00) | d;
      if (regWrEn && a == 2) nxt = (nxt & 16'h00FF) | (d << 8);
      if (wrap) mFlag = 1;
      else if (vecAck) mFlag = 0;
      else if (regWrEn && a == 0) mFlag = (d >> 5) & 1;
      if (regWrEn && a == 0) begin
        mGate = (d >> 7) & 1; mSrc = (d >> 6) & 1; mRun = (d >> 4) & 1; mLow = d & 15;
      end
      if (regWrEn && a == 3) mReload = (mReload & 16'hFF00) | d;
      if (regWrEn && a == 4) mReload = (mReload & 16'h00FF) | (d << 8);
      mCount = nxt;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (!done) begin
      check({phaseTag, " flag"}, int'(ovfFlag), mFlag);
      check({phaseTag, " read"}, int'(regRdData), modelReg(int'(regAddr)));
    end
  end

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdExp(input string tag, input int a, input int exp);
    @(negedge clk);
    regAddr = 3'(a);
    @(posedge clk);
    #2;
    check(tag, int'(regRdData), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extEventPin = 1'b0; idle(30);
      extEventPin = 1'b1; idle(30);
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    idle(4);
    rdExp("R1", 0, 0); rdExp("R1", 1, 0); rdExp("R1", 2, 0);
    rdExp("R1", 3, 0); rdExp("R1", 4, 0);
    check("R1 ovf", int'(ovfFlag), 0);
    @(negedge clk) rstN = 1'b1;

    phaseTag = "R2";
    wrReg(3, 8'h34); wrReg(4, 8'h12); wrReg(1, 8'hF0); wrReg(2, 8'hFF);
    rdExp("R2", 3, 8'h34); rdExp("R2", 4, 8'h12);
    rdExp("R2", 1, 8'hF0); rdExp("R2", 2, 8'hFF); rdExp("R2", 6, 0);

    phaseTag = "R10";
    wrReg(0, 8'h0A); idle(50);
    rdExp("R10", 0, 8'h0A); rdExp("R10 no count", 1, 8'hF0);

    phaseTag = "R5";
    check("R5 stopped", 1, 1); rdExp("R5 stopped", 2, 8'hFF);

    phaseTag = "R3";
    wrReg(0, 8'h10); idle(100);
    rdExp("R3", 1, modelReg(1));
    phaseTag = "R6";
    idle(140);
    rdExp("R6", 2, 8'h12);
    rdExp("R7", 0, 8'h30);
    check("R7 out", int'(ovfFlag), 1);

    phaseTag = "R8";
    @(negedge clk) vecAck = 1'b1; @(negedge clk) vecAck = 1'b0;
    rdExp("R8 ack", 0, 8'h10);

    phaseTag = "R5";
    wrReg(0, 8'h00); wrReg(1, 8'h00); wrReg(2, 8'h01);
    gatePin = 1'b0; wrReg(0, 8'h90); idle(100);
    rdExp("R5 gated", 1, 8'h00); rdExp("R5 gated", 2, 8'h01);
    gatePin = 1'b1; idle(120);
    rdExp("R5 open", 1, modelReg(1));
    check("R5 moved", int'(modelReg(1) != 0), 1);

    phaseTag = "R4";
    wrReg(0, 8'h00); wrReg(1, 8'h00); wrReg(2, 8'h00);
    wrReg(0, 8'h50); idle(40);
    pulses(3); idle(40);
    rdExp("R4", 1, 3); rdExp("R4", 2, 0);

    phaseTag = "R8";
    wrReg(0, 8'h00); wrReg(3, 8'h00); wrReg(4, 8'h00);
    wrReg(1, 8'hFF); wrReg(2, 8'hFF); wrReg(0, 8'h50);
    @(negedge clk) vecAck = 1'b1;
    pulses(1);
    @(negedge clk) vecAck = 1'b0;
    rdExp("R8", 1, 0); rdExp("R8", 0, 8'h50);

    phaseTag = "R9";
    wrReg(0, 8'h00); wrReg(3, 8'hAB); wrReg(4, 8'hCD);
    wrReg(1, 8'hFF); wrReg(2, 8'hFF); wrReg(0, 8'h10);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 8'hFF;
    idle(14);
    regWrEn = 1'b0;
    rdExp("R9 lo", 1, 8'hFF); rdExp("R9 hi", 2, modelReg(2));
    check("R9 hi from reload", int'(modelReg(2) >= 8'hCD), 1);
    check("R9 flag", int'(ovfFlag), 1);

    idle(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    done = 1'b1;
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired, got running expected finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule